// File: doc/BRIEF.md
# Packed 24-bit Pixel Unpacker

This block streams one scan line of true-colour pixels out of a linear frame buffer in which every pixel takes three bytes back to back. A one-cycle pulse on `line_start` captures the line's start address and its length, counted in groups of eight pixels. From then on the block reads 32-bit words from a synchronous memory port with a fixed read latency of one cycle. It gathers the bytes, which cross word boundaries, in a small staging buffer and hands out one 24-bit RGB pixel per accepted beat on a valid/ready output.

The line's first byte address is the programmed start value shifted left by one, so a line can begin halfway into a word. A whole group of eight pixels (24 bytes) is read only if it lies entirely below the frame-buffer size `MEM_BYTES`. The first group that would cross that bound ends the line, and no later group of that line is read or emitted. While a line is still in progress, further line-start pulses are ignored.

Top module: `pku24_unpack`

## Requirements
- R1: The byte address of the line's first pixel is `line_base` shifted left by one bit. Memory words are little-endian: byte k of word address w is the byte at address 4w+k, carried on `mem_rd_data[8k+7:8k]`. Pixel p of the line uses the bytes at addresses A+3p, A+3p+1 and A+3p+2, including a pixel that straddles two words.
- R2: In each pixel the byte at the lowest address is blue and goes to `pix_data[7:0]`. The next byte is green and goes to `pix_data[15:8]`. The byte at the highest address is red and goes to `pix_data[23:16]`.
- R3: A line with G groups and no size limit hit emits exactly 8·G pixels, in address order, with none missing or repeated.
- R4: A group that starts at byte address S is emitted only if S+24 ≤ `MEM_BYTES`. The first group that fails this test ends the line. A group that ends exactly at `MEM_BYTES` is still emitted.
- R5: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and `pix_data` does not change in the next cycle.
- R6: During and right after reset, `pix_valid` and `mem_rd_en` are low.
- R7: A `line_start` pulse that arrives before the previous line's last pixel has been accepted is ignored and changes neither the pixels nor the reads.
- R8: A line with zero groups issues no memory read and emits no pixel.
- R9: Within a line, reads go to consecutive word addresses. Exactly the words that hold at least one byte of an emitted group are read, each once.
- R10: A read is issued only when the staging buffer can take the whole word, so its occupancy never exceeds `BUF_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse that starts a line when idle |
| line_base | input | AW-1 | Start value; byte address is this shifted left by one |
| line_groups | input | GRP_W | Number of 8-pixel groups in the line |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW-2 | Word address of the read |
| mem_rd_data | input | 32 | Read word, valid the cycle after the strobe |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Downstream accepts the pixel |
| pix_data | output | 24 | Pixel: red 23:16, green 15:8, blue 7:0 |

## Verification
The bench builds the unpacker with `MEM_BYTES` = 256, `GRP_W` = 4 and `BUF_BYTES` = 8. With a 256-byte frame buffer, a line of a few groups can be placed so that it stops short of the bound, ends exactly on it, or cannot fit even one group. Four-bit group counts keep each line short. The smallest staging buffer forces the read throttle to act on almost every word, and together with a randomly toggled `pix_ready` it exercises stalls on both sides of the buffer, from even start addresses on and off word boundaries.

// File: rtl/pku_pkg.sv
package pku_pkg;

  // Valid byte span of a returned word: first byte lane and byte count
  typedef struct packed {
    logic [1:0] lo;
    logic [2:0] n;
  } pku_lane_t;

  function automatic int occ_width(input int buf_bytes);
    return $clog2(buf_bytes + 1);
  endfunction

endpackage

// File: rtl/pku_fetch.sv
module pku_fetch
  import pku_pkg::*;
#(
  parameter int AW        = 20,
  parameter int GW        = 8,
  parameter int MEM_BYTES = 1 << 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_byte,
  input  logic [GW-1:0] groups,
  input  logic          room,
  output logic          active,
  output logic          rd_en,
  output logic [AW-3:0] rd_addr,
  output logic          rd_pend,
  output pku_lane_t     rd_lane
);
  localparam int EW = AW + 2;
  localparam logic [EW-1:0] LIM   = EW'(MEM_BYTES);
  localparam logic [EW-1:0] STEP  = EW'(24);
  localparam logic [EW-1:0] STEP2 = EW'(48);
  localparam logic [EW-1:0] WORD  = EW'(4);

  logic [EW-1:0] base_q, front_q, wp_q, start_ext, first_wp, span;
  logic [GW-1:0] left_q;
  logic          done_q, issue, finish, last_w;
  logic [1:0]    lane_lo;
  logic [2:0]    lane_hi;

  assign start_ext = EW'(base_byte);
  assign first_wp  = {base_q[EW-1:2], 2'b00};
  assign issue     = active && (front_q != base_q) && (wp_q < front_q) && room;
  assign finish    = active && done_q && ((front_q == base_q) || (wp_q >= front_q));
  assign rd_en     = issue;
  assign rd_addr   = wp_q[AW-1:2];

  always_comb begin
    lane_lo = (wp_q == first_wp) ? base_q[1:0] : 2'd0;
    last_w  = done_q && ((wp_q + WORD) > front_q);
    span    = front_q - wp_q;
    lane_hi = last_w ? span[2:0] : 3'd4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rd_pend <= 1'b0;
      rd_lane <= '0;
      base_q  <= '0;
      front_q <= '0;
      wp_q    <= '0;
      left_q  <= '0;
      done_q  <= 1'b1;
    end else begin
      rd_pend <= issue;
      if (issue) begin
        rd_lane.lo <= lane_lo;
        rd_lane.n  <= lane_hi - {1'b0, lane_lo};
      end
      if (start) begin
        active  <= 1'b1;
        base_q  <= start_ext;
        front_q <= start_ext;
        wp_q    <= {start_ext[EW-1:2], 2'b00};
        left_q  <= groups;
        done_q  <= (groups == '0) || ((start_ext + STEP) > LIM);
      end else if (active) begin
        if (!done_q) begin
          front_q <= front_q + STEP;
          left_q  <= left_q - 1'b1;
          done_q  <= (left_q == GW'(1)) || ((front_q + STEP2) > LIM);
        end
        if (issue) wp_q <= wp_q + WORD;
        if (finish) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pku_gather.sv
module pku_gather
  import pku_pkg::*;
#(
  parameter int BUF_BYTES = 12,
  localparam int CW = occ_width(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   in_word,
  input  pku_lane_t     in_lane,
  input  logic          take,
  output logic [CW-1:0] occ,
  output logic          avail,
  output logic [23:0]   pix
);
  logic [7:0]    b_q [BUF_BYTES];
  logic [7:0]    b_n [BUF_BYTES];
  logic [CW-1:0] keep, occ_n;

  assign avail = occ >= CW'(3);
  assign pix   = {b_q[2], b_q[1], b_q[0]};

  always_comb begin
    keep = occ - (take ? CW'(3) : CW'(0));
    for (int i = 0; i < BUF_BYTES; i++) begin
      if (take) b_n[i] = (i + 3 < BUF_BYTES) ? b_q[(i + 3) % BUF_BYTES] : 8'h00;
      else      b_n[i] = b_q[i];
    end
    for (int i = 0; i < BUF_BYTES; i++) begin
      for (int k = 0; k < 4; k++) begin
        if (in_valid && (3'(k) < in_lane.n) && ((keep + CW'(k)) == CW'(i)))
          b_n[i] = in_word[8*(int'(in_lane.lo) + k) +: 8];
      end
    end
    occ_n = keep + (in_valid ? CW'(in_lane.n) : CW'(0));
  end

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ_n;
    b_q <= b_n;
  end
endmodule

// File: rtl/pku_outstage.sv
module pku_outstage (
  input  logic        clk,
  input  logic        rst,
  input  logic        avail,
  input  logic [23:0] pix_in,
  input  logic        ready,
  output logic        take,
  output logic        valid,
  output logic [23:0] data
);
  assign take = avail && (!valid || ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (take) begin
      valid <= 1'b1;
      data  <= pix_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pku24_unpack.sv
module pku24_unpack
  import pku_pkg::*;
#(
  parameter int MEM_BYTES = 1 << 20,
  parameter int GRP_W     = 8,
  parameter int BUF_BYTES = 12,
  localparam int AW    = $clog2(MEM_BYTES),
  localparam int OCC_W = occ_width(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic [AW-2:0]    line_base,
  input  logic [GRP_W-1:0] line_groups,
  output logic             mem_rd_en,
  output logic [AW-3:0]    mem_rd_addr,
  input  logic [31:0]      mem_rd_data,
  output logic             pix_valid,
  input  logic             pix_ready,
  output logic [23:0]      pix_data
);
  localparam int RW = OCC_W + 2;

  logic          f_active, rd_pend, room, idle, accept, g_avail, take;
  logic [OCC_W-1:0] g_occ;
  logic [23:0]   g_pix;
  pku_lane_t     rd_lane;

  assign idle   = !f_active && !rd_pend && (g_occ == '0) && !pix_valid;
  assign accept = line_start && idle;
  assign room   = (RW'(g_occ) + (rd_pend ? RW'(4) : RW'(0)) + RW'(4)) <= RW'(BUF_BYTES);

  pku_fetch #(.AW(AW), .GW(GRP_W), .MEM_BYTES(MEM_BYTES)) fetch_i (
    .clk(clk), .rst(rst), .start(accept), .base_byte({line_base, 1'b0}),
    .groups(line_groups), .room(room), .active(f_active), .rd_en(mem_rd_en),
    .rd_addr(mem_rd_addr), .rd_pend(rd_pend), .rd_lane(rd_lane)
  );

  pku_gather #(.BUF_BYTES(BUF_BYTES)) gather_i (
    .clk(clk), .rst(rst), .in_valid(rd_pend), .in_word(mem_rd_data),
    .in_lane(rd_lane), .take(take), .occ(g_occ), .avail(g_avail), .pix(g_pix)
  );

  pku_outstage out_i (
    .clk(clk), .rst(rst), .avail(g_avail), .pix_in(g_pix), .ready(pix_ready),
    .take(take), .valid(pix_valid), .data(pix_data)
  );
endmodule

// File: rtl/pku24_unpack_chk.sv
module pku24_unpack_chk #(
  parameter int AW        = 20,
  parameter int BUF_BYTES = 12,
  localparam int OCC_W = pku_pkg::occ_width(BUF_BYTES)
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_rd_en,
  input logic [AW-3:0]    mem_rd_addr,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic [23:0]      pix_data,
  input logic [OCC_W-1:0] occ
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!pix_valid && !mem_rd_en)); // R6

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data))); // R5

  AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == (AW-2)'($past(mem_rd_addr) + 1'b1))); // R9

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(BUF_BYTES)); // R10
endmodule

bind pku24_unpack pku24_unpack_chk #(.AW(AW), .BUF_BYTES(BUF_BYTES)) chk_i (
  .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data), .occ(g_occ)
);

// File: tb/pku24_unpack_tb_top.sv
`timescale 1ns/1ps
module pku24_unpack_tb_top;
  localparam int MEMB = 256;
  localparam int GW   = 4;
  localparam int BUFB = 8;
  localparam int AW   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          line_start = 1'b0;
  logic [AW-2:0] line_base  = '0;
  logic [GW-1:0] line_groups = '0;
  logic          mem_rd_en;
  logic [AW-3:0] mem_rd_addr;
  logic [31:0]   mem_rd_data = '0;
  logic          pix_valid;
  logic          pix_ready = 1'b1;
  logic [23:0]   pix_data;

  pku24_unpack #(.MEM_BYTES(MEMB), .GRP_W(GW), .BUF_BYTES(BUFB)) dut_i (
    .clk(clk), .rst(rst), .line_start(line_start), .line_base(line_base),
    .line_groups(line_groups), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  int          rd_cnt = 0;
  string       tag = "R6";
  logic [23:0] expq[$];
  logic [15:0] lfsr = 16'hACE1;
  bit          rnd_rdy = 1'b0;

  function automatic logic [7:0] fb(input int a);
    return 8'((a * 97 + 29) ^ (a >> 3));
  endfunction

  // memory model: little-endian words, one cycle latency (R1)
  always @(posedge clk)
    if (mem_rd_en)
      mem_rd_data <= {fb(4*int'(mem_rd_addr)+3), fb(4*int'(mem_rd_addr)+2),
                      fb(4*int'(mem_rd_addr)+1), fb(4*int'(mem_rd_addr))};

  task automatic check(input bit ok, input string t, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  // monitor: scoreboard compare on each accepted beat
  always @(negedge clk) begin
    if (!rst) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_ready = rnd_rdy ? (lfsr[0] | lfsr[5]) : 1'b1;
      if (mem_rd_en) rd_cnt++;
      if (pix_valid && pix_ready) begin
        if (expq.size() == 0) check(1'b0, tag, "unexpected pixel (R3)", int'(pix_data), 0);
        else begin
          logic [23:0] e;
          e = expq.pop_front();
          check(pix_data === e, tag, "pixel R1 R2", int'(pix_data), int'(e));
        end
      end
    end
  end

  task automatic pulse(input int b7, input int g);
    @(negedge clk);
    line_base = (AW-1)'(b7);
    line_groups = GW'(g);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  // driver: push expected pixels, start a line, wait for drain
  task automatic run_line(input string t, input int b7, input int g, input bit rr,
                          input bit intr, input int ib7, input int ig);
    int a, geff, exp_rd;
    tag = t;
    rnd_rdy = rr;
    a = 2 * b7;
    geff = 0;
    while (geff < g && a + 24 * (geff + 1) <= MEMB) geff++;
    for (int p = 0; p < 8 * geff; p++)
      expq.push_back({fb(a+3*p+2), fb(a+3*p+1), fb(a+3*p)});
    exp_rd = (geff == 0) ? 0 : ((a + 24*geff + 3) / 4) - (a / 4);
    @(negedge clk);
    rd_cnt = 0;
    pulse(b7, g);
    if (intr) begin
      repeat (3) @(negedge clk);
      pulse(ib7, ig);   // R7: must be ignored
    end
    while (expq.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    check(rd_cnt == exp_rd, t, "read count R9", rd_cnt, exp_rd);
    check(pix_valid == 1'b0, t, "idle after line R3", int'(pix_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(pix_valid == 1'b0, "R6", "pix_valid in reset", int'(pix_valid), 0);
    check(mem_rd_en == 1'b0, "R6", "mem_rd_en in reset", int'(mem_rd_en), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pix_valid == 1'b0, "R6", "pix_valid after reset", int'(pix_valid), 0);
    run_line("R1_R2_R3 aligned", 0, 2, 1'b0, 1'b0, 0, 0);
    run_line("R1 straddle", 1, 3, 1'b1, 1'b0, 0, 0);
    run_line("R3 single", 10, 1, 1'b0, 1'b0, 0, 0);
    run_line("R5 stall", 7, 4, 1'b1, 1'b0, 0, 0);
    run_line("R8 zero", 5, 0, 1'b0, 1'b0, 0, 0);
    run_line("R4 cut", 100, 5, 1'b1, 1'b0, 0, 0);
    run_line("R4 exact", 116, 2, 1'b0, 1'b0, 0, 0);
    run_line("R4 none", 120, 3, 1'b0, 1'b0, 0, 0);
    run_line("R7 ignore", 3, 3, 1'b1, 1'b1, 40, 2);
    run_line("R10 full", 0, 10, 1'b1, 1'b0, 0, 0);
    run_line("R9 back", 61, 5, 1'b0, 1'b0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule